// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory

This block is a behavioural, synthesizable model of a pipelined synchronous static memory with burst addressing and single-cycle deselect. Every address and control input is captured on the rising clock edge. An access is opened by one of two active-low strobes: a processor-side strobe or a controller-side strobe. After that, an internal two-bit counter walks through a four-word burst, either in linear order or in interleaved order. Writes commit on a clock edge with a per-lane byte mask, or all four lanes are written at once through a global write input.

Read data passes through a request register and then an output register, so the data for a captured address is driven after the next rising edge. The output-enable input and the sleep input gate the drive signal directly, with no clock edge in between. Instead of a tristate bus, the data bus is modelled as a data output `dq_o` plus a drive qualifier `dq_drv`. While sleep is held high, the block performs no access and keeps its contents.

Top module: `sbsram_core`

## Requirements
- R1: The device counts as selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 are all true at the same edge.
- R2: A read captured at rising edge n drives `dq_o` with `dq_drv`=1 after edge n+1. This lasts until edge n+2, which updates it again.
- R3: When `strb_p_n`=0 at an edge while selected, a read starts at `addr`, and all write enables are ignored in that cycle. When `strb_p_n`=0 while not selected, the strobe is ignored.
- R4: When `strb_c_n`=0 at an edge where R3 starts no access, one of two things happens. If selected, an access starts at `addr`; it is a write when the R5/R6 lane mask is nonzero and a read otherwise. If not selected, the burst ends and `dq_drv` is 0 after the next edge.
- R5: When `gwe_n`=0, all four lanes are written, whatever the values of `bwe_n` and `be_n`.
- R6: When `gwe_n`=1 and `bwe_n`=0, lane i (bits 8i+7..8i) is written exactly when `be_n[i]`=0. When `gwe_n`=1 and `bwe_n`=1, the access is a read.
- R7: On an edge with no new start and no deselect during an open burst, one word is accessed. If `adv_n`=0, the counter k advances first; if `adv_n`=1, it holds. The word address keeps the base upper bits. Its low two bits are (base+k) mod 4 when `lin_mode`=1 at the start, and base XOR k when `lin_mode`=0.
- R8: When `oe_n`=1, `dq_drv` is 0 immediately, with no clock edge needed.
- R9: While `sleep`=1, `dq_drv` is 0, no access is performed (a request captured just before is abandoned), the burst ends and memory contents are kept. The first edge with `sleep`=0 is processed normally.
- R10: After reset, `dq_drv` is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | AW | Word address |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| strb_p_n | input | 1 | Processor-side start strobe, active low |
| strb_c_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lin_mode | input | 1 | Burst order: 1 linear, 0 interleaved |
| gwe_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | 4 | Per-lane write enables, active low |
| din | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Powerdown request |
| dq_o | output | 32 | Read data |
| dq_drv | output | 1 | Bus drive qualifier (0 means high impedance) |

## Verification
The hardest state to reach is a sleep request that arrives in the middle of a burst while a write already sits in the request register. In that case the pending write must be dropped and the burst must not resume afterwards. The stimulus opens a burst, starts a write and raises sleep on the very next edge. It then reads the same word back after release. A long randomized phase then mixes chip-enable combinations, both strobes, advance patterns, output enable and short sleep pulses against a cycle-by-cycle reference.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // low two address bits of burst beat k from base b
  function automatic logic [1:0] burst_lsb(input logic [1:0] b, input logic [1:0] k,
                                           input logic lin);
    return lin ? (b + k) : (b ^ k);
  endfunction

  // lanes written in this cycle; all zero means read
  function automatic logic [LANES-1:0] lane_mask(input logic gwe_n, input logic bwe_n,
                                                 input logic [LANES-1:0] be_n);
    if (!gwe_n)      return '1;
    else if (!bwe_n) return ~be_n;
    else             return '0;
  endfunction
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [AW-1:0]     addr,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              strb_p_n,
  input  logic              strb_c_n,
  input  logic              adv_n,
  input  logic              lin_mode,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] din,
  output logic              req_v,
  output logic [LANES-1:0]  req_mask,
  output logic [AW-1:0]     req_addr,
  output logic [DATA_W-1:0] req_data
);
  logic             active;
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             mode_q;
  logic [1:0]       cnt_nxt;
  logic [LANES-1:0] cur_mask;
  logic [AW-1:0]    beat_addr;

  // named events used by the assertions
  logic sel_w, start_p, start_c, c_desel, cont_ev, p_ignored;

  assign sel_w     = !cs1_n && cs2 && !cs3_n;
  assign start_p   = !sleep && !strb_p_n && sel_w;
  assign start_c   = !sleep && !start_p && !strb_c_n && sel_w;
  assign c_desel   = !sleep && !start_p && !strb_c_n && !sel_w;
  assign cont_ev   = !sleep && !start_p && strb_c_n && active;
  assign p_ignored = !sleep && !strb_p_n && !sel_w && strb_c_n && !active;

  assign cnt_nxt   = adv_n ? cnt_q : cnt_q + 2'd1;
  assign cur_mask  = lane_mask(gwe_n, bwe_n, be_n);
  assign beat_addr = {base_q[AW-1:2], burst_lsb(base_q[1:0], cnt_nxt, mode_q)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mode_q   <= 1'b0;
      req_v    <= 1'b0;
      req_mask <= '0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      req_data <= din;
      if (start_p || start_c) begin
        active   <= 1'b1;
        base_q   <= addr;
        cnt_q    <= 2'd0;
        mode_q   <= lin_mode;
        req_v    <= 1'b1;
        req_addr <= addr;
        req_mask <= start_p ? '0 : cur_mask;
      end else if (cont_ev) begin
        cnt_q    <= cnt_nxt;
        req_v    <= 1'b1;
        req_addr <= beat_addr;
        req_mask <= cur_mask;
      end else begin
        req_v    <= 1'b0;
        req_mask <= '0;
        if (sleep || c_desel) active <= 1'b0;
      end
    end
  end

  // R3
  proc_start_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (req_v && req_mask == '0));
  // R3
  proc_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_ignored |=> !req_v);
  // R4
  cache_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_desel |=> (!req_v && !active));
  // R9
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!req_v && !active));
  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_ev && adv_n) |=> $stable(req_addr));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              req_v,
  input  logic [LANES-1:0]  req_mask,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic rd_fire, wr_fire;

  assign rd_fire = !sleep && req_v && (req_mask == '0);
  assign wr_fire = !sleep && req_v && (req_mask != '0);

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int l = 0; l < LANES; l++) begin
        if (req_mask[l]) mem[req_addr][l*LANE_W +: LANE_W] <= req_data[l*LANE_W +: LANE_W];
      end
    end
    if (rd_fire) dout <= mem[req_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= rd_fire;
  end

  // R2
  read_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v && req_mask == '0 && !sleep) |=> out_valid);
  // R9
  sleep_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !out_valid);
  // R6
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v && req_mask != '0) |=> !out_valid);
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              strb_p_n,
  input  logic              strb_c_n,
  input  logic              adv_n,
  input  logic              lin_mode,
  input  logic              gwe_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_drv
);
  logic              req_v;
  logic [LANES-1:0]  req_mask;
  logic [AW-1:0]     req_addr;
  logic [DATA_W-1:0] req_data;
  logic              out_valid;

  sbsram_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .lin_mode(lin_mode),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n), .din(din),
    .req_v(req_v), .req_mask(req_mask), .req_addr(req_addr), .req_data(req_data)
  );

  sbsram_array #(.AW(AW)) array_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .req_v(req_v), .req_mask(req_mask), .req_addr(req_addr), .req_data(req_data),
    .out_valid(out_valid), .dout(dq_o)
  );

  assign dq_drv = out_valid && !oe_n && !sleep;

  // R2
  drive_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !sleep && !$past(sleep) && $past(req_v) && $past(req_mask) == '0) |-> dq_drv);
endmodule

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic strb_p_n = 1'b1, strb_c_n = 1'b1, adv_n = 1'b1, lin_mode = 1'b1;
  logic gwe_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] be_n = 4'hF;
  logic [31:0] din = '0;
  logic oe_n = 1'b0, sleep = 1'b0;
  logic [31:0] dq_o;
  logic dq_drv;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R10";
  bit running = 0;

  always #5 clk = ~clk;

  sbsram_core #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n), .lin_mode(lin_mode),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .be_n(be_n), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dq_o(dq_o), .dq_drv(dq_drv)
  );

  // ---------------- behavioural reference ----------------
  int unsigned ref_mem [NW];
  bit  m_open, m_lin, p_valid, o_valid;
  int  m_base, m_k, p_addr, p_mask;
  int unsigned p_data, o_data;

  function automatic int beat(int base, int k, bit lin);
    int lo;
    if (lin) lo = ((base % 4) + k) % 4;
    else     lo = (base % 4) ^ k;
    return (base / 4) * 4 + lo;
  endfunction

  function automatic int wmask();
    if (gwe_n == 1'b0) return 15;
    if (bwe_n == 1'b0) return (~be_n) & 15;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; p_valid = 0; o_valid = 0;
    end else if (sleep) begin
      m_open = 0; p_valid = 0; o_valid = 0;
    end else begin
      bit chosen;
      chosen = (cs1_n == 0) && (cs2 == 1) && (cs3_n == 0);
      // output stage
      o_valid = p_valid && p_mask == 0;
      if (o_valid) o_data = ref_mem[p_addr];
      if (p_valid && p_mask != 0)
        for (int l = 0; l < 4; l++)
          if (p_mask[l]) begin
            ref_mem[p_addr][l*8 +: 8] = p_data[l*8 +: 8];
          end
      // request stage
      p_data = din;
      if (strb_p_n == 0 && chosen) begin
        m_open = 1; m_base = addr; m_k = 0; m_lin = lin_mode;
        p_valid = 1; p_addr = addr; p_mask = 0;
      end else if (strb_c_n == 0) begin
        if (chosen) begin
          m_open = 1; m_base = addr; m_k = 0; m_lin = lin_mode;
          p_valid = 1; p_addr = addr; p_mask = wmask();
        end else begin
          m_open = 0; p_valid = 0;
        end
      end else if (m_open) begin
        if (adv_n == 0) m_k = (m_k + 1) % 4;
        p_valid = 1; p_addr = beat(m_base, m_k, m_lin); p_mask = wmask();
      end else begin
        p_valid = 0;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && running) begin
      bit exp_drv;
      exp_drv = o_valid && !oe_n && !sleep;
      checks++;
      if (dq_drv !== exp_drv) begin
        fails++;
        $display("FAIL %s dq_drv act=%0b exp=%0b t=%0t", tag, dq_drv, exp_drv, $time);
      end else if (exp_drv) begin
        checks++;
        if (dq_o !== o_data) begin
          fails++;
          $display("FAIL %s dq_o act=%08h exp=%08h t=%0t", tag, dq_o, o_data, $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    strb_p_n = 1; strb_c_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; be_n = 4'hF;
    cs1_n = 0; cs2 = 1; cs3_n = 0;
  endtask

  task automatic c_op(input int a, input bit g_n, input bit b_n, input [3:0] be,
                      input [31:0] d);
    idle(); addr = a[AW-1:0]; strb_c_n = 0; gwe_n = g_n; bwe_n = b_n; be_n = be; din = d;
    step();
  endtask

  task automatic desel();
    idle(); strb_c_n = 0; cs2 = 0; step(); idle();
  endtask

  task automatic do_check(input bit cond, input string t, input [31:0] act, input [31:0] exp_v);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", t, act, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    do_check(dq_drv == 0, "R10 reset drive", {31'b0, dq_drv}, 0);
    rst_n = 1; running = 1;
    step();
    do_check(dq_drv == 0, "R10 idle after reset", {31'b0, dq_drv}, 0);

    // R5: global write fills memory, overriding be_n/bwe_n
    tag = "R5";
    for (int a = 0; a < NW; a++) c_op(a, 0, a[0], a[3:0], 32'hC3000000 ^ (a * 32'h00010307));
    desel(); step();
    for (int a = 0; a < NW; a += 5) begin c_op(a, 1, 1, 4'h0, 0); desel(); end
    step();

    // R6: byte lanes
    tag = "R6";
    for (int m = 0; m < 16; m++) begin
      c_op(m + 8, 1, 0, m[3:0], 32'h11223344 + m);
      desel();
      c_op(m + 8, 1, 1, 4'h0, 0);
      desel();
    end
    step();

    // R3: processor strobe never writes; ignored when deselected
    tag = "R3";
    idle(); addr = 6'd3; strb_p_n = 0; gwe_n = 0; din = 32'hDEADBEEF; step();
    desel(); step();
    c_op(3, 1, 1, 4'hF, 0); desel();
    idle(); addr = 6'd9; strb_p_n = 0; cs3_n = 1; step(); idle(); step(); step();
    do_check(dq_drv == 0, "R3 ignored strobe no drive", {31'b0, dq_drv}, 0);

    // R1/R4: all chip-enable combinations with the controller strobe
    tag = "R1";
    for (int c = 0; c < 8; c++) begin
      c_op(20 + c, 1, 1, 4'hF, 0);
      idle(); strb_c_n = 0; cs1_n = c[0]; cs2 = c[1]; cs3_n = c[2]; addr = 6'd30; step();
      idle(); step(); step();
    end
    tag = "R4";
    c_op(12, 1, 1, 4'hF, 0); desel(); step();
    do_check(dq_drv == 0, "R4 deselected no drive", {31'b0, dq_drv}, 0);

    // R7: bursts in both orders with advance patterns
    tag = "R7";
    for (int mode = 0; mode < 2; mode++)
      for (int b = 0; b < 4; b++) begin
        idle(); lin_mode = mode[0]; addr = 6'd40 + b[5:0]; strb_p_n = 0; step();
        idle();
        for (int s = 0; s < 6; s++) begin adv_n = s[0] & s[1]; step(); end
        desel();
      end
    step();

    // R8: output enable acts without a clock edge
    tag = "R8";
    c_op(5, 1, 1, 4'hF, 0); idle(); step();
    @(negedge clk); #1;
    oe_n = 1; #1;
    do_check(dq_drv == 0, "R8 oe_n high async", {31'b0, dq_drv}, 0);
    oe_n = 0; #1;
    do_check(dq_drv == 1, "R8 oe_n low async", {31'b0, dq_drv}, 1);
    step(); desel(); step();

    // R9: sleep with a pending write mid burst
    tag = "R9";
    idle(); addr = 6'd16; strb_c_n = 0; step();
    idle(); adv_n = 0; gwe_n = 0; din = 32'h0BADF00D; sleep = 0; step();
    idle(); sleep = 1; step(); step(); step();
    do_check(dq_drv == 0, "R9 asleep no drive", {31'b0, dq_drv}, 0);
    sleep = 0; step(); step();
    do_check(dq_drv == 0, "R9 burst ended", {31'b0, dq_drv}, 0);
    c_op(17, 1, 1, 4'hF, 0); desel(); step();

    // mixed random traffic over all requirements
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      idle();
      addr = r[AW-1:0];
      din = $urandom;
      cs1_n = (r[8:6] == 0); cs2 = (r[11:9] != 0); cs3_n = (r[14:12] == 0);
      strb_p_n = (r[17:15] != 0); strb_c_n = (r[20:18] != 0);
      adv_n = r[21]; lin_mode = r[22];
      gwe_n = (r[25:23] != 0); bwe_n = r[26]; be_n = r[30:27];
      oe_n = (r[15:9] == 0);
      sleep = (r[31:24] == 8'hFF);
      step();
    end
    idle(); sleep = 0; oe_n = 0; step(); step();

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule